// File: doc/BRIEF.md
# Sliding-Window Register File

This block holds a physical file of 128 registers and shows instructions a 32-entry logical view of it. The first eight logical indices reach a fixed set of global registers that every window shares. The other 24 indices reach window-local registers, at an offset that a movable window pointer sets. Software moves the pointer with a set command. The block can then give each iteration of a loop a fresh group of registers without using more bits to name them.

Instruction operands use two combinational read ports and one write port. Memory traffic uses a separate preload write port and a separate poststore read port. Each of these two carries its own window offset, which is added to the active pointer. A load can therefore fill a window ahead of the active one, and a store can drain a window behind it, while arithmetic runs in the current window. Reads see writes made in the same cycle. When a preload and an operand write hit the same physical register, the operand write wins and a clash flag is raised.

Top module: `swrf_top`

## Requirements
- R1: After reset, every register reads 0 and the window pointer `ptr_o` is 0.
- R2: Logical indices 0 to 7 map to physical registers 0 to 7, whatever the pointer and offset. A value written there can be read back unchanged after the pointer moves.
- R3: Logical index i in the range 8 to 31 maps to physical register 8 + ((base + i - 8) mod 120). For operand ports, base is the pointer. Windows that are 24 or more apart do not share a local register.
- R4: When `ptr_set_i` is 1, the pointer takes `ptr_val_i` mod 120 at the next clock edge. When `ptr_set_i` is 0, the pointer holds its value.
- R5: An operand write in the same cycle as a pointer set is placed using the old pointer.
- R6: The read ports `rd_a`, `rd_b` and `ps` work write-first. A read of a register being written in the same cycle returns the operand write data if that write hits it, otherwise the preload data. Data written this way is not stored unless a clock edge occurs.
- R7: A preload writes `pl_data_i` to the register at base = (pointer + (`pl_off_i` mod 120)) mod 120. A poststore reads from base = (pointer + (`ps_off_i` mod 120)) mod 120.
- R8: When a preload and an operand write target the same physical register in one cycle, the operand data is stored. `pl_clash_o` is 1 in that cycle and 0 whenever the two targets differ or either write is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| rd_a_idx_i | input | 5 | Operand read A logical index |
| rd_a_data_o | output | 32 | Operand read A data |
| rd_b_idx_i | input | 5 | Operand read B logical index |
| rd_b_data_o | output | 32 | Operand read B data |
| wr_en_i | input | 1 | Operand write enable |
| wr_idx_i | input | 5 | Operand write logical index |
| wr_data_i | input | 32 | Operand write data |
| ptr_set_i | input | 1 | Load a new window pointer |
| ptr_val_i | input | 7 | New pointer value (taken mod 120) |
| ptr_o | output | 7 | Active window pointer |
| pl_en_i | input | 1 | Preload write enable |
| pl_off_i | input | 7 | Preload window offset from the pointer |
| pl_idx_i | input | 5 | Preload logical index |
| pl_data_i | input | 32 | Preload data |
| ps_off_i | input | 7 | Poststore window offset from the pointer |
| ps_idx_i | input | 5 | Poststore logical index |
| ps_data_o | output | 32 | Poststore read data |
| pl_clash_o | output | 1 | Preload and operand write hit the same register |

## Verification
Two pairs of functions can fall in the same cycle. A pointer set can coincide with an operand write. A preload can coincide with an operand write to the same physical register. The bench provokes the first by asserting the set and the write together. It then judges where the data went by reading the register back under both the new pointer and the old one. It provokes the second by aiming a preload at the operand write's register, which is seen as the clash flag, as the bypassed read in that cycle, and as the stored value afterwards. A second preload aimed at a different register must leave the flag low and land normally.

// File: rtl/swrf_pkg.sv
package swrf_pkg;
  localparam int unsigned LN_RDA = 0;
  localparam int unsigned LN_RDB = 1;
  localparam int unsigned LN_WR  = 2;
  localparam int unsigned LN_PL  = 3;
  localparam int unsigned LN_PS  = 4;
  localparam int unsigned NLANE  = 5;
  localparam int unsigned NRD    = 3;
endpackage

// File: rtl/swrf_ptr.sv
module swrf_ptr #(
  parameter int unsigned SPAN  = 120,
  parameter int unsigned PTR_W = 7
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             set_i,
  input  logic [PTR_W-1:0] val_i,
  output logic [PTR_W-1:0] ptr_o
);
  logic [PTR_W-1:0] ptr_q, val_red;

  // single subtract suffices while 2*SPAN > 2**PTR_W - 1
  assign val_red = (32'(val_i) >= SPAN) ? PTR_W'(32'(val_i) - SPAN) : val_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    ptr_q <= '0;
    else if (set_i) ptr_q <= val_red;
  end

  assign ptr_o = ptr_q;

  p_ptr_range_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    32'(ptr_q) < SPAN);
  p_ptr_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !set_i |=> $stable(ptr_q));
endmodule

// File: rtl/swrf_map.sv
module swrf_map #(
  parameter int unsigned NPHYS = 128,
  parameter int unsigned NGLB  = 8,
  parameter int unsigned SPAN  = NPHYS - NGLB,
  parameter int unsigned PTR_W = 7,
  parameter int unsigned LA_W  = 5,
  parameter int unsigned PA_W  = 7
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [PTR_W-1:0] ptr_i,
  input  logic [PTR_W-1:0] off_i,
  input  logic [LA_W-1:0]  idx_i,
  output logic [PA_W-1:0]  phys_o
);
  int unsigned off_red, base, rel;

  always_comb begin
    off_red = 32'(off_i);
    if (off_red >= SPAN) off_red = off_red - SPAN;
    base = 32'(ptr_i) + off_red;
    if (base >= SPAN) base = base - SPAN;
    rel = base + 32'(idx_i) - NGLB;
    if (rel >= SPAN) rel = rel - SPAN;
    if (32'(idx_i) < NGLB) phys_o = PA_W'(idx_i);
    else                   phys_o = PA_W'(NGLB + rel);
  end

  p_phys_range_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    32'(phys_o) < NPHYS);
  p_local_floor_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (32'(idx_i) >= NGLB) |-> (32'(phys_o) >= NGLB));
endmodule

// File: rtl/swrf_array.sv
module swrf_array
  import swrf_pkg::*;
#(
  parameter int unsigned DW    = 32,
  parameter int unsigned NPHYS = 128,
  parameter int unsigned PA_W  = 7
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            wr_en_i,
  input  logic [PA_W-1:0] wr_phys_i,
  input  logic [DW-1:0]   wr_data_i,
  input  logic            pl_en_i,
  input  logic [PA_W-1:0] pl_phys_i,
  input  logic [DW-1:0]   pl_data_i,
  input  logic [PA_W-1:0] rd_phys_i [NRD],
  output logic [DW-1:0]   rd_data_o [NRD],
  output logic            clash_o
);
  logic [DW-1:0] mem [NPHYS];

  assign clash_o = wr_en_i && pl_en_i && (wr_phys_i == pl_phys_i);

  // operand write issued last so it wins a clash
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < int'(NPHYS); i++) mem[i] <= '0;
    end else begin
      if (pl_en_i) mem[pl_phys_i] <= pl_data_i;
      if (wr_en_i) mem[wr_phys_i] <= wr_data_i;
    end
  end

  for (genvar r = 0; r < int'(NRD); r++) begin : g_rd
    always_comb begin
      if (wr_en_i && wr_phys_i == rd_phys_i[r])      rd_data_o[r] = wr_data_i;
      else if (pl_en_i && pl_phys_i == rd_phys_i[r]) rd_data_o[r] = pl_data_i;
      else                                           rd_data_o[r] = mem[rd_phys_i[r]];
    end
  end

  p_clash_keep_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clash_o |=> mem[$past(wr_phys_i)] == $past(wr_data_i));
  p_pl_lands_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pl_en_i && !(wr_en_i && wr_phys_i == pl_phys_i))
      |=> mem[$past(pl_phys_i)] == $past(pl_data_i));
endmodule

// File: rtl/swrf_top.sv
module swrf_top
  import swrf_pkg::*;
#(
  parameter int unsigned DW    = 32,
  parameter int unsigned NPHYS = 128,
  parameter int unsigned NLOG  = 32,
  parameter int unsigned NGLB  = 8,
  localparam int unsigned SPAN  = NPHYS - NGLB,
  localparam int unsigned PTR_W = $clog2(SPAN),
  localparam int unsigned LA_W  = $clog2(NLOG),
  localparam int unsigned PA_W  = $clog2(NPHYS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [LA_W-1:0]  rd_a_idx_i,
  output logic [DW-1:0]    rd_a_data_o,
  input  logic [LA_W-1:0]  rd_b_idx_i,
  output logic [DW-1:0]    rd_b_data_o,
  input  logic             wr_en_i,
  input  logic [LA_W-1:0]  wr_idx_i,
  input  logic [DW-1:0]    wr_data_i,
  input  logic             ptr_set_i,
  input  logic [PTR_W-1:0] ptr_val_i,
  output logic [PTR_W-1:0] ptr_o,
  input  logic             pl_en_i,
  input  logic [PTR_W-1:0] pl_off_i,
  input  logic [LA_W-1:0]  pl_idx_i,
  input  logic [DW-1:0]    pl_data_i,
  input  logic [PTR_W-1:0] ps_off_i,
  input  logic [LA_W-1:0]  ps_idx_i,
  output logic [DW-1:0]    ps_data_o,
  output logic             pl_clash_o
);
  logic [PTR_W-1:0] ptr_q;
  logic [LA_W-1:0]  lane_idx  [NLANE];
  logic [PTR_W-1:0] lane_off  [NLANE];
  logic [PA_W-1:0]  lane_phys [NLANE];
  logic [PA_W-1:0]  rd_phys   [NRD];
  logic [DW-1:0]    rd_data   [NRD];

  swrf_ptr #(.SPAN(SPAN), .PTR_W(PTR_W)) u_ptr (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .set_i (ptr_set_i),
    .val_i (ptr_val_i),
    .ptr_o (ptr_q)
  );

  assign lane_idx[LN_RDA] = rd_a_idx_i;
  assign lane_idx[LN_RDB] = rd_b_idx_i;
  assign lane_idx[LN_WR]  = wr_idx_i;
  assign lane_idx[LN_PL]  = pl_idx_i;
  assign lane_idx[LN_PS]  = ps_idx_i;

  assign lane_off[LN_RDA] = '0;
  assign lane_off[LN_RDB] = '0;
  assign lane_off[LN_WR]  = '0;
  assign lane_off[LN_PL]  = pl_off_i;
  assign lane_off[LN_PS]  = ps_off_i;

  // every lane sees the pointer of the current cycle; a set lands at the edge
  for (genvar l = 0; l < int'(NLANE); l++) begin : g_lane
    swrf_map #(
      .NPHYS(NPHYS), .NGLB(NGLB), .SPAN(SPAN),
      .PTR_W(PTR_W), .LA_W(LA_W), .PA_W(PA_W)
    ) u_map (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .ptr_i (ptr_q),
      .off_i (lane_off[l]),
      .idx_i (lane_idx[l]),
      .phys_o(lane_phys[l])
    );
  end

  assign rd_phys[0] = lane_phys[LN_RDA];
  assign rd_phys[1] = lane_phys[LN_RDB];
  assign rd_phys[2] = lane_phys[LN_PS];

  swrf_array #(.DW(DW), .NPHYS(NPHYS), .PA_W(PA_W)) u_array (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_en_i  (wr_en_i),
    .wr_phys_i(lane_phys[LN_WR]),
    .wr_data_i(wr_data_i),
    .pl_en_i  (pl_en_i),
    .pl_phys_i(lane_phys[LN_PL]),
    .pl_data_i(pl_data_i),
    .rd_phys_i(rd_phys),
    .rd_data_o(rd_data),
    .clash_o  (pl_clash_o)
  );

  assign rd_a_data_o = rd_data[0];
  assign rd_b_data_o = rd_data[1];
  assign ps_data_o   = rd_data[2];
  assign ptr_o       = ptr_q;

  p_clash_needs_both_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pl_clash_o |-> (wr_en_i && pl_en_i));
  p_set_lands_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ptr_set_i && 32'(ptr_val_i) < SPAN) |=> ptr_o == $past(ptr_val_i));
endmodule

// File: tb/swrf_top_bench.sv
module swrf_top_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  rd_a_idx = '0, rd_b_idx = '0, wr_idx = '0, pl_idx = '0, ps_idx = '0;
  logic [31:0] rd_a_data, rd_b_data, ps_data;
  logic        wr_en = 1'b0, ptr_set = 1'b0, pl_en = 1'b0;
  logic [31:0] wr_data = '0, pl_data = '0;
  logic [6:0]  ptr_val = '0, pl_off = '0, ps_off = '0, ptr;
  logic        clash;
  int          n_run = 0, n_fail = 0;

  always #5 clk = ~clk;

  swrf_top u_swrf_top (
    .clk_i(clk), .rst_ni(rst_n),
    .rd_a_idx_i(rd_a_idx), .rd_a_data_o(rd_a_data),
    .rd_b_idx_i(rd_b_idx), .rd_b_data_o(rd_b_data),
    .wr_en_i(wr_en), .wr_idx_i(wr_idx), .wr_data_i(wr_data),
    .ptr_set_i(ptr_set), .ptr_val_i(ptr_val), .ptr_o(ptr),
    .pl_en_i(pl_en), .pl_off_i(pl_off), .pl_idx_i(pl_idx), .pl_data_i(pl_data),
    .ps_off_i(ps_off), .ps_idx_i(ps_idx), .ps_data_o(ps_data),
    .pl_clash_o(clash)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle();
    wr_en = 1'b0; pl_en = 1'b0; ptr_set = 1'b0;
  endtask

  task automatic set_ptr(input logic [6:0] v);
    ptr_set = 1'b1; ptr_val = v; tick(); ptr_set = 1'b0;
  endtask

  task automatic wr(input logic [4:0] i, input logic [31:0] d);
    wr_en = 1'b1; wr_idx = i; wr_data = d; tick(); wr_en = 1'b0;
  endtask

  task automatic rd_a(input string req, input logic [4:0] i, input logic [31:0] exp);
    rd_a_idx = i; #1; chk(req, rd_a_data, exp);
  endtask

  task automatic t_reset();
    chk("R1 ptr", 32'(ptr), 32'd0);
    rd_a("R1 idx0", 5'd0, 32'd0);
    rd_a("R1 idx8", 5'd8, 32'd0);
    rd_a("R1 idx31", 5'd31, 32'd0);
    ps_idx = 5'd20; #1; chk("R1 ps", ps_data, 32'd0);
  endtask

  task automatic t_global();
    wr(5'd3, 32'hA1A1_0003);
    set_ptr(7'd50);
    rd_a("R2 global after move", 5'd3, 32'hA1A1_0003);
    ps_off = 7'd17; ps_idx = 5'd3; #1; chk("R2 global via poststore", ps_data, 32'hA1A1_0003);
  endtask

  task automatic t_local();
    set_ptr(7'd0);
    wr(5'd8, 32'hB1B1_0008);
    set_ptr(7'd24);
    rd_a("R3 private window", 5'd8, 32'd0);
    set_ptr(7'd119);
    rd_a("R3 wrap to phys8", 5'd9, 32'hB1B1_0008);
    wr(5'd31, 32'hB2B2_001E);
    set_ptr(7'd0);
    rd_a("R3 wrap phys30", 5'd30, 32'hB2B2_001E);
  endtask

  task automatic t_ptr();
    set_ptr(7'd125);
    chk("R4 set mod 120", 32'(ptr), 32'd5);
    tick();
    chk("R4 hold", 32'(ptr), 32'd5);
    set_ptr(7'd119);
    chk("R4 set max", 32'(ptr), 32'd119);
  endtask

  task automatic t_wr_ptr();
    set_ptr(7'd5);
    ptr_set = 1'b1; ptr_val = 7'd40;
    wr_en = 1'b1; wr_idx = 5'd10; wr_data = 32'hC1C1_000F;
    tick(); idle();
    chk("R5 new ptr", 32'(ptr), 32'd40);
    rd_a("R5 not at new window", 5'd10, 32'd0);
    set_ptr(7'd5);
    rd_a("R5 at old window", 5'd10, 32'hC1C1_000F);
  endtask

  task automatic t_bypass();
    set_ptr(7'd5);
    wr_en = 1'b1; wr_idx = 5'd12; wr_data = 32'hD1D1_0011;
    rd_b_idx = 5'd12; ps_off = 7'd0; ps_idx = 5'd12;
    rd_a("R6 bypass a", 5'd12, 32'hD1D1_0011);
    chk("R6 bypass b", rd_b_data, 32'hD1D1_0011);
    chk("R6 bypass ps", ps_data, 32'hD1D1_0011);
    wr_en = 1'b0;
    pl_en = 1'b1; pl_off = 7'd10; pl_idx = 5'd8; pl_data = 32'hD2D2_0017;
    rd_b_idx = 5'd18; #1;
    chk("R6 preload bypass", rd_b_data, 32'hD2D2_0017);
    pl_en = 1'b0;
    rd_a("R6 no store without edge", 5'd12, 32'd0);
  endtask

  task automatic t_preload();
    set_ptr(7'd5);
    pl_en = 1'b1; pl_off = 7'd30; pl_idx = 5'd9; pl_data = 32'hE1E1_002C;
    tick(); idle();
    ps_off = 7'd30; ps_idx = 5'd9; #1;
    chk("R7 poststore ahead", ps_data, 32'hE1E1_002C);
    set_ptr(7'd35);
    rd_a("R7 preload landed", 5'd9, 32'hE1E1_002C);
    set_ptr(7'd100);
    pl_en = 1'b1; pl_off = 7'd50; pl_idx = 5'd8; pl_data = 32'hE2E2_0026;
    tick(); idle();
    set_ptr(7'd30);
    rd_a("R7 offset wrap", 5'd8, 32'hE2E2_0026);
    set_ptr(7'd0);
    pl_en = 1'b1; pl_off = 7'd127; pl_idx = 5'd10; pl_data = 32'hE3E3_0011;
    tick(); idle();
    set_ptr(7'd7);
    rd_a("R7 offset mod 120", 5'd10, 32'hE3E3_0011);
  endtask

  task automatic t_clash();
    set_ptr(7'd0);
    wr_en = 1'b1; wr_idx = 5'd8; wr_data = 32'hF1F1_0008;
    pl_en = 1'b1; pl_off = 7'd0; pl_idx = 5'd8; pl_data = 32'h6161_0008;
    #1;
    chk("R8 clash flag", 32'(clash), 32'd1);
    rd_a("R8 read during clash", 5'd8, 32'hF1F1_0008);
    tick(); idle(); #1;
    chk("R8 flag idle", 32'(clash), 32'd0);
    rd_a("R8 operand wins", 5'd8, 32'hF1F1_0008);
    wr_en = 1'b1; wr_idx = 5'd8; wr_data = 32'hF2F2_0008;
    pl_en = 1'b1; pl_off = 7'd1; pl_idx = 5'd30; pl_data = 32'h6262_001F;
    #1;
    chk("R8 no clash distinct", 32'(clash), 32'd0);
    tick(); idle();
    rd_a("R8 operand stored", 5'd8, 32'hF2F2_0008);
    ps_off = 7'd1; ps_idx = 5'd30; #1;
    chk("R8 preload stored", ps_data, 32'h6262_001F);
  endtask

  initial begin
    #100_000_0;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_global();
    t_local();
    t_ptr();
    t_wr_ptr();
    t_bypass();
    t_preload();
    t_clash();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule